// File: doc/BRIEF.md
# Synchronized Clock-Group Stop Controller

This block gates twenty clock outputs arranged in three groups: a processor group of 2, a peripheral-bus group of 5 and a memory group of 13. It runs on a fast oversampling clock and treats every source clock as a sampled signal. Each output has its own enable bit, supplied as a parallel register word. Each group also has an active-low stop pin, and one power-down pin covers the whole device. An output runs only when both its enable bit and its group's pin allow it.

A gate opens or closes only while its sampled source is low. For the processor and peripheral groups there is an additional condition: a rising edge of the free-running peripheral reference clock must come first, and the falling edge of the output's own source follows it. Because of this, no output ever shows a shortened high pulse.

A mode input turns the four control pins into non-control pins. When the mode input is 1, stop and power-down are unavailable and only the register bits decide which outputs run. After reset, every output stays low until an oscillator settle interval has elapsed. That interval is set in oversampling cycles.

Top module: `clkstop_ctrl`

## Requirements
- R1: Enable bit i of `en_reg` gates one output. Bits 1:0 map to `cpu_clk[1:0]`, bits 6:2 map to `pci_clk[4:0]` and bits 19:7 map to `sdr_clk[12:0]`. An output runs only when its bit is 1 and its group's control pin allows it.
- R2: A gated output is held low. Every high pulse it produces lasts exactly as long as the high phase of its source clock.
- R3: A processor-group or peripheral-group output changes between running and stopped only after a rising edge of `ref_clk_in`, followed later by a falling edge of that output's own source.
- R4: `ctl_n` bit 0 is processor stop, bit 1 is peripheral stop, bit 2 is memory stop and bit 3 is power-down, all active low, and only while `mode` is 0. While `mode` is 1 these pins have no effect.
- R5: While `mode` is 0 and power-down is low, all group outputs, `ref_clk_out` and `osc_run` are low, whatever the three stop pins are set to.
- R6: With power-down high, each stop pin forces only its own group low. Any combination of the three stop pins is accepted, and `osc_run` stays high.
- R7: After reset, all outputs and `osc_run` stay low until `SETTLE_CYC` oversampling cycles have elapsed.
- R8: `ref_clk_out` is never gated by the peripheral stop pin. It runs whenever the oscillator runs.
- R9: A memory-group output changes state at its own source's falling edge and does not wait for the reference clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk_in | input | 1 | Free-running peripheral reference source |
| cpu_src | input | 1 | Processor group source clock |
| pci_src | input | 1 | Peripheral group source clock |
| sdr_src | input | 1 | Memory group source clock |
| mode | input | 1 | 0: control pins active; 1: control pins ignored |
| ctl_n | input | 4 | Active-low stop/power-down pins (see R4) |
| en_reg | input | 20 | Per-output enable bits (see R1) |
| cpu_clk | output | 2 | Gated processor clocks |
| pci_clk | output | 5 | Gated peripheral clocks |
| sdr_clk | output | 13 | Gated memory clocks |
| ref_clk_out | output | 1 | Reference clock output |
| osc_run | output | 1 | Oscillator-running indicator |

## Verification
The bench holds the reference clock still and then pulls the processor stop pin. A design that ignored the reference rule would stop the processor outputs at once, while a correct one keeps them running. In the same window the memory stop must still act, which catches a design that wrongly applies the reference rule to the memory group. Every high pulse on every output is measured against its source's high width, so a gate that switches mid-pulse shows up as a runt. Pin patterns under mode 1, power-down with stops mixed in, and the silent settle window expose pin decoding that ignores the mode input, leaks through power-down, or starts early.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

    typedef struct packed {
        logic cpu;
        logic pci;
        logic sdr;
        logic osc;
    } grp_allow_t;

    localparam int PIN_CPU = 0;
    localparam int PIN_PCI = 1;
    localparam int PIN_SDR = 2;
    localparam int PIN_PWR = 3;

    function automatic grp_allow_t decode_pins(input logic mode_i, input logic [3:0] pins_n);
        grp_allow_t a;
        if (mode_i) begin
            a = '{cpu: 1'b1, pci: 1'b1, sdr: 1'b1, osc: 1'b1};
        end else begin
            a.osc = pins_n[PIN_PWR];
            a.cpu = pins_n[PIN_PWR] & pins_n[PIN_CPU];
            a.pci = pins_n[PIN_PWR] & pins_n[PIN_PCI];
            a.sdr = pins_n[PIN_PWR] & pins_n[PIN_SDR];
        end
        return a;
    endfunction

endpackage

// File: rtl/clkstop_settle.sv
module clkstop_settle #(
    parameter int SETTLE_CYC = 1200000,
    localparam int CW = $clog2(SETTLE_CYC + 1)
) (
    input  logic clk,
    input  logic rst,
    output logic settled
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            settled <= 1'b0;
        end else if (!settled) begin
            if (cnt == CW'(SETTLE_CYC - 1)) begin
                settled <= 1'b1;
            end
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/clkstop_edge.sv
module clkstop_edge (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic q,
    output logic rise,
    output logic fall
);
    logic s1, prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1   <= 1'b0;
            q    <= 1'b0;
            prev <= 1'b0;
        end else begin
            s1   <= din;
            q    <= s1;
            prev <= q;
        end
    end

    assign rise = q & ~prev;
    assign fall = prev & ~q;
endmodule

// File: rtl/clkstop_lane.sv
module clkstop_lane #(
    parameter bit USE_REF = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic want,
    input  logic ref_rise,
    input  logic src_fall,
    output logic run,
    output logic armed
);
    logic may_switch;

    assign may_switch = src_fall & (armed | !USE_REF);

    always_ff @(posedge clk) begin
        if (rst) begin
            run   <= 1'b0;
            armed <= 1'b0;
        end else if (want == run) begin
            armed <= 1'b0;
        end else if (may_switch) begin
            run   <= want;
            armed <= 1'b0;
        end else if (ref_rise) begin
            armed <= 1'b1;
        end
    end
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
    import clkstop_pkg::*;
#(
    parameter int N_CPU      = 2,
    parameter int N_PCI      = 5,
    parameter int N_SDR      = 13,
    parameter int SETTLE_CYC = 1200000,
    localparam int N_REF_SYNC = N_CPU + N_PCI,
    localparam int N_ALL      = N_CPU + N_PCI + N_SDR
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_clk_in,
    input  logic             cpu_src,
    input  logic             pci_src,
    input  logic             sdr_src,
    input  logic             mode,
    input  logic [3:0]       ctl_n,
    input  logic [N_ALL-1:0] en_reg,
    output logic [N_CPU-1:0] cpu_clk,
    output logic [N_PCI-1:0] pci_clk,
    output logic [N_SDR-1:0] sdr_clk,
    output logic             ref_clk_out,
    output logic             osc_run
);
    logic       settled;
    grp_allow_t allow;
    logic       ref_q, ref_rise, ref_fall;
    logic       cpu_q, cpu_rise, cpu_fall;
    logic       pci_q, pci_rise, pci_fall;
    logic       sdr_q, sdr_rise, sdr_fall;
    logic [N_ALL-1:0] want, run, armed;
    logic       ref_run, ref_armed;
    logic [N_ALL-1:0] src_vec;

    clkstop_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk(clk), .rst(rst), .settled(settled));

    clkstop_edge u_ref (.clk(clk), .rst(rst), .din(ref_clk_in),
        .q(ref_q), .rise(ref_rise), .fall(ref_fall));
    clkstop_edge u_cpu (.clk(clk), .rst(rst), .din(cpu_src),
        .q(cpu_q), .rise(cpu_rise), .fall(cpu_fall));
    clkstop_edge u_pci (.clk(clk), .rst(rst), .din(pci_src),
        .q(pci_q), .rise(pci_rise), .fall(pci_fall));
    clkstop_edge u_sdr (.clk(clk), .rst(rst), .din(sdr_src),
        .q(sdr_q), .rise(sdr_rise), .fall(sdr_fall));

    assign allow   = decode_pins(mode, ctl_n);
    assign src_vec = {{N_SDR{sdr_q}}, {N_PCI{pci_q}}, {N_CPU{cpu_q}}};

    for (genvar i = 0; i < N_ALL; i++) begin : g_lane
        logic grp_ok, lane_fall;
        if (i < N_CPU) begin : g_cpu
            assign grp_ok    = allow.cpu;
            assign lane_fall = cpu_fall;
        end else if (i < N_REF_SYNC) begin : g_pci
            assign grp_ok    = allow.pci;
            assign lane_fall = pci_fall;
        end else begin : g_sdr
            assign grp_ok    = allow.sdr;
            assign lane_fall = sdr_fall;
        end
        assign want[i] = settled & en_reg[i] & grp_ok;

        clkstop_lane #(.USE_REF(i < N_REF_SYNC)) u_lane (
            .clk(clk), .rst(rst), .want(want[i]), .ref_rise(ref_rise),
            .src_fall(lane_fall), .run(run[i]), .armed(armed[i]));
    end

    clkstop_lane #(.USE_REF(1'b0)) u_ref_lane (
        .clk(clk), .rst(rst), .want(settled & allow.osc), .ref_rise(1'b0),
        .src_fall(ref_fall), .run(ref_run), .armed(ref_armed));

    always_ff @(posedge clk) begin
        if (rst) osc_run <= 1'b0;
        else     osc_run <= settled & allow.osc;
    end

    assign cpu_clk     = src_vec[N_CPU-1:0] & run[N_CPU-1:0];
    assign pci_clk     = src_vec[N_REF_SYNC-1:N_CPU] & run[N_REF_SYNC-1:N_CPU];
    assign sdr_clk     = src_vec[N_ALL-1:N_REF_SYNC] & run[N_ALL-1:N_REF_SYNC];
    assign ref_clk_out = ref_q & ref_run;
endmodule

// File: rtl/clkstop_ctrl_chk.sv
module clkstop_ctrl_chk #(
    parameter int NA = 7,
    parameter int NT = 20
) (
    input logic          clk,
    input logic          rst,
    input logic          mode,
    input logic [3:0]    ctl_n,
    input logic          settled,
    input logic [3:0]    allow_bits,
    input logic [NT-1:0] run,
    input logic [NT-1:0] armed,
    input logic [NT-1:0] src_vec,
    input logic [NT-1:0] outs,
    input logic          ref_clk_out,
    input logic          osc_run
);
    p_change_low_r2: assert property (@(posedge clk) disable iff (rst)
        ((run ^ $past(run)) & src_vec) == '0);

    p_ref_first_r3: assert property (@(posedge clk) disable iff (rst)
        ((run[NA-1:0] ^ $past(run[NA-1:0])) & ~$past(armed[NA-1:0])) == '0);

    p_mode_ignore_r4: assert property (@(posedge clk) disable iff (rst)
        mode |-> (allow_bits == 4'hF));

    p_pd_off_r5: assert property (@(posedge clk) disable iff (rst)
        (settled && !mode && !ctl_n[3]) |=> !osc_run);

    p_settle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !settled |-> (outs == '0 && !osc_run && !ref_clk_out));
endmodule

bind clkstop_ctrl clkstop_ctrl_chk #(.NA(N_REF_SYNC), .NT(N_ALL)) u_chk (
    .clk(clk), .rst(rst), .mode(mode), .ctl_n(ctl_n), .settled(settled),
    .allow_bits(allow), .run(run), .armed(armed), .src_vec(src_vec),
    .outs({sdr_clk, pci_clk, cpu_clk}), .ref_clk_out(ref_clk_out),
    .osc_run(osc_run));

// File: tb/tb_clkstop_ctrl.sv
module tb_clkstop_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_clk_in = 1'b0, cpu_src = 1'b0, pci_src = 1'b0, sdr_src = 1'b0;
    logic        mode = 1'b0;
    logic [3:0]  ctl_n = 4'hF;
    logic [19:0] en_reg = 20'hFFFFF;
    logic [1:0]  cpu_clk;
    logic [4:0]  pci_clk;
    logic [12:0] sdr_clk;
    logic        ref_clk_out, osc_run;

    int total = 0, bad = 0, runts = 0;
    logic [2:0]  cnt = '0;
    logic        ref_req = 1'b1, ref_run = 1'b1;
    logic [20:0] seen;
    logic        done = 1'b0;

    clkstop_ctrl #(.SETTLE_CYC(50)) dut (
        .clk(clk), .rst(rst), .ref_clk_in(ref_clk_in), .cpu_src(cpu_src),
        .pci_src(pci_src), .sdr_src(sdr_src), .mode(mode), .ctl_n(ctl_n),
        .en_reg(en_reg), .cpu_clk(cpu_clk), .pci_clk(pci_clk), .sdr_clk(sdr_clk),
        .ref_clk_out(ref_clk_out), .osc_run(osc_run));

    always #2.5 clk = ~clk;

    // source generator: ref and pci period 8, cpu and sdr period 4
    initial forever begin
        @(negedge clk);
        cnt = cnt + 1'b1;
        if (cnt == 3'd0) ref_run = ref_req;
        ref_clk_in = ref_run & cnt[2];
        pci_src    = ~cnt[2];
        cpu_src    = cnt[1];
        sdr_src    = ~cnt[1];
    end

    // pulse-width monitor for R2
    initial begin
        int hl [21];
        logic [20:0] prev = '0;
        logic [20:0] cur;
        foreach (hl[k]) hl[k] = 0;
        forever begin
            @(negedge clk);
            cur = {ref_clk_out, sdr_clk, pci_clk, cpu_clk};
            for (int k = 0; k < 21; k++) begin
                if (cur[k]) hl[k]++;
                else if (prev[k]) begin
                    if (hl[k] != (((k >= 2 && k < 7) || k == 20) ? 4 : 2)) runts++;
                    hl[k] = 0;
                end
            end
            prev = cur;
        end
    end

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic observe(input int n);
        seen = '0;
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            seen |= {ref_clk_out, sdr_clk, pci_clk, cpu_clk};
        end
    endtask

    // {mode, ctl_n, en_reg, expected running mask, expected osc}
    localparam logic [45:0] VEC [10] = '{
        {1'b0, 4'b1111, 20'hFFFFF, 20'hFFFFF, 1'b1},
        {1'b0, 4'b1110, 20'hFFFFF, 20'hFFFFC, 1'b1},
        {1'b0, 4'b1101, 20'hFFFFF, 20'hFFF83, 1'b1},
        {1'b0, 4'b1011, 20'hFFFFF, 20'h0007F, 1'b1},
        {1'b0, 4'b0111, 20'hFFFFF, 20'h00000, 1'b0},
        {1'b0, 4'b0000, 20'hFFFFF, 20'h00000, 1'b0},
        {1'b1, 4'b0000, 20'hFFFFF, 20'hFFFFF, 1'b1},
        {1'b0, 4'b1111, 20'hA5A5A, 20'hA5A5A, 1'b1},
        {1'b0, 4'b1100, 20'h5A5A5, 20'h5A580, 1'b1},
        {1'b1, 4'b0111, 20'h0F0F0, 20'h0F0F0, 1'b1}
    };

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            check(1'b0, "watchdog", cyc, 20000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        // R7: quiet during settle interval
        observe(40);
        check(seen == '0, "R7 outputs during settle", seen, 0);
        check(osc_run == 1'b0, "R7 osc_run during settle", osc_run, 0);
        observe(60);
        check(seen == 21'h1FFFFF, "R7 outputs after settle", seen, 21'h1FFFFF);

        for (int v = 0; v < 10; v++) begin
            mode   = VEC[v][45];
            ctl_n  = VEC[v][44:41];
            en_reg = VEC[v][40:21];
            repeat (64) @(negedge clk);
            observe(32);
            check(seen[19:0] == VEC[v][20:1], $sformatf("R1 R4 R6 vector %0d", v), seen[19:0], VEC[v][20:1]);
            check(osc_run == VEC[v][0], $sformatf("R5 R6 osc vector %0d", v), osc_run, VEC[v][0]);
            check(seen[20] == VEC[v][0], $sformatf("R8 R5 ref vector %0d", v), seen[20], VEC[v][0]);
        end

        // R3 / R9: reference held still
        mode = 1'b0; ctl_n = 4'hF; en_reg = 20'hFFFFF;
        repeat (64) @(negedge clk);
        ref_req = 1'b0;
        repeat (24) @(negedge clk);
        ctl_n = 4'b1010;
        repeat (24) @(negedge clk);
        observe(32);
        check(seen[1:0] == 2'b11, "R3 cpu keeps running without reference edge", seen[1:0], 2'b11);
        check(seen[19:7] == '0, "R9 sdram stops without reference edge", seen[19:7], 0);
        ref_req = 1'b1;
        repeat (40) @(negedge clk);
        observe(32);
        check(seen[1:0] == 2'b00, "R3 cpu stops after reference edge", seen[1:0], 0);
        check(seen[6:2] == 5'h1F, "R6 pci unaffected by cpu stop", seen[6:2], 5'h1F);

        // R7: reset mid-run silences and re-settles
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        ctl_n = 4'hF;
        observe(40);
        check(seen == '0, "R7 quiet after second reset", seen, 0);
        observe(60);
        check(seen == 21'h1FFFFF, "R7 running after second settle", seen, 21'h1FFFFF);

        check(runts == 0, "R2 runt pulses", runts, 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule